// File: doc/BRIEF.md
# Real-Time Clock Periodic Interrupt Generator

This block produces the periodic interrupt request of a real-time clock and keeps the flag byte that software polls or acknowledges. Software programs a control byte that holds a time-base code and a 4-bit rate code, and a second control byte that holds the periodic enable. A free-running tick enable paces a countdown. Each time the countdown runs out while the enable is on, the block raises a periodic flag and drives the interrupt request high.

A status byte collects the periodic flag together with the update-ended and alarm flags. Those two flags come from neighbouring logic as one-cycle event pulses. A read of the status byte hands back the current flags and then wipes them. The countdown length in ticks is derived from the parameter `TICK_HZ`, the tick rate, divided by the selected interrupt rate.

Top module: `rtc_periodic_irq`

## Requirements
- R1: After synchronous reset, `irq` is low, every status flag is zero (a status read returns 0x00), the periodic enable is off and the rate code is 0.
- R2: Rate code 0 (control A bits [3:0]) stops the periodic interrupt: no flag and no request ever come from the countdown.
- R3: Rate codes 3 to 15 select 8192 Hz down to 2 Hz, halving per step, for any time-base code. The countdown length is `TICK_HZ` divided by that rate, in ticks.
- R4: Time-base code 3'b010 (control A bits [6:4]) is the 32 kHz base. On that base rate code 1 gives 256 Hz and rate code 2 gives 128 Hz. On any other time-base code (3'b000 = 4 MHz, 3'b001 = 1 MHz) they give 32768 Hz and 16384 Hz.
- R5: The countdown moves only in cycles where `tick_en` is high.
- R6: A control A write (`wr_sel` = 0) keeps only bits [6:0] and restarts the countdown at a full period of the newly written setting. Bit 7 has no effect.
- R7: A control B write (`wr_sel` = 1) restarts the countdown only when it changes the periodic enable (bit 6). Rewriting the same enable value leaves the countdown running.
- R8: A control B write with bit 6 clear drops `irq` on the next cycle and leaves the status flags untouched.
- R9: When the countdown expires with the enable on, the periodic flag (status bit 6) and `irq` are set. The countdown reloads with the period added to the remainder, so successive events stay exactly one period apart.
- R10: Status byte layout: bit 4 is update-ended (set by `upd_evt`), bit 5 is alarm (set by `alm_evt`), bit 6 is periodic, and bit 7 is the OR of bits 6..4. Bits 3..0 read 0. Update and alarm events do not raise `irq`.
- R11: A status read (`rd_c`) returns the flags in the same cycle, clears all flags in the next cycle and drops `irq`.
- R12: A flag event that lands in the same cycle as a status read survives the clear. The read returns the old value, and the new flag (and `irq` for a periodic event) remains set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Free-running tick enable that paces the countdown |
| wr_en | input | 1 | Control register write strobe |
| wr_sel | input | 1 | Write target: 0 = control A (rate/time base), 1 = control B (enable) |
| wr_data | input | 8 | Write data byte |
| rd_c | input | 1 | Status byte read strobe |
| rd_data | output | 8 | Status byte, valid while `rd_c` is high |
| upd_evt | input | 1 | Update-ended event pulse from the calendar logic |
| alm_evt | input | 1 | Alarm match event pulse |
| irq | output | 1 | Periodic interrupt request, active high |

## Verification
Two operations can collide in one cycle: a countdown expiry and a status read that clears the flags. The bench arms an 8-tick period and places the read strobe exactly on the clock edge where the countdown reaches zero. It then expects that read to return 0x00, `irq` to be high afterwards, and a second read to return 0xC0. Separately, control writes are placed partway through a period to tell apart a restart (a full period follows) from no restart (only the remainder follows).

// File: rtl/rtc_pir_pkg.sv
package rtc_pir_pkg;

  // control A fields
  localparam int RATE_LSB = 0;
  localparam int BASE_LSB = 4;
  localparam logic [2:0] BASE_32K = 3'b010;
  // control B
  localparam int PIE_BIT = 6;

  typedef struct packed {
    logic uf;
    logic af;
    logic pf;
  } flags_t;

  // log2 of the interrupt rate in Hz for a rate code (code 0 is unused)
  function automatic logic [3:0] rate_shift(input logic [3:0] code, input logic slow_base);
    logic [3:0] sh;
    case (code)
      4'd0:    sh = 4'd0;
      4'd1:    sh = slow_base ? 4'd8 : 4'd15;
      4'd2:    sh = slow_base ? 4'd7 : 4'd14;
      default: sh = 4'(5'd16 - {1'b0, code});
    endcase
    return sh;
  endfunction

  // ticks per interrupt period; never below one tick
  function automatic int unsigned ticks_per_period(input int unsigned tick_hz, input logic [3:0] sh);
    int unsigned p;
    p = tick_hz >> sh;
    return (p == 0) ? 1 : p;
  endfunction

endpackage

// File: rtl/rtc_rate_decode.sv
module rtc_rate_decode
  import rtc_pir_pkg::*;
#(
  parameter int unsigned TICK_HZ = 65536,
  parameter int CW = 18
) (
  input  logic [3:0]    rate_code,
  input  logic [2:0]    base_code,
  output logic [CW-1:0] period,
  output logic          rate_on
);
  logic       slow_base;
  logic [3:0] shift_amt;

  assign slow_base = (base_code == BASE_32K);
  assign shift_amt = rate_shift(rate_code, slow_base);
  assign period    = CW'(ticks_per_period(TICK_HZ, shift_amt));
  assign rate_on   = (rate_code != 4'd0);

  always_comb begin
    assert (!rate_on || period != '0)
      else $error("p_period_nonzero_r3 violated");
  end
endmodule

// File: rtl/rtc_period_timer.sv
module rtc_period_timer #(
  parameter int CW = 18,
  parameter int STEP = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          active,
  input  logic          reload,
  input  logic [CW-1:0] period,
  output logic          fire,
  output logic [CW-1:0] remain
);
  localparam logic [CW-1:0] STEP_C = CW'(STEP);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_dec;
  logic [CW-1:0] cnt_carry;
  logic          advance;

  assign advance   = active && tick_en && !reload;
  assign fire      = advance && (cnt_q <= STEP_C);
  assign cnt_dec   = cnt_q - STEP_C;
  assign cnt_carry = cnt_q + period - STEP_C;
  assign remain    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (reload)    cnt_q <= period;
    else if (fire)      cnt_q <= cnt_carry;
    else if (advance)   cnt_q <= cnt_dec;
  end

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!reload && !(active && tick_en)) |=> $stable(cnt_q))
    else $error("p_idle_hold_r2");

  p_reload_full_r6: assert property (@(posedge clk) disable iff (rst)
    reload |=> (cnt_q == $past(period)))
    else $error("p_reload_full_r6");

  p_tick_gate_r5: assert property (@(posedge clk) disable iff (rst)
    !tick_en |-> !fire)
    else $error("p_tick_gate_r5");
endmodule

// File: rtl/rtc_flag_reg.sv
module rtc_flag_reg
  import rtc_pir_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fire,
  input  logic       upd_evt,
  input  logic       alm_evt,
  input  logic       rd_c,
  input  logic       pie_drop,
  output logic [7:0] status,
  output logic       irq
);
  flags_t fl_q;
  logic   irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fl_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      fl_q.uf <= upd_evt | (fl_q.uf & ~rd_c);
      fl_q.af <= alm_evt | (fl_q.af & ~rd_c);
      fl_q.pf <= fire    | (fl_q.pf & ~rd_c);
      irq_q   <= fire    | (irq_q & ~rd_c & ~pie_drop);
    end
  end

  assign status = {(fl_q.uf | fl_q.af | fl_q.pf), fl_q.pf, fl_q.af, fl_q.uf, 4'b0000};
  assign irq    = irq_q;

  p_irq_needs_pf_r9: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> fl_q.pf)
    else $error("p_irq_needs_pf_r9");

  p_fire_sets_r9: assert property (@(posedge clk) disable iff (rst)
    fire |=> (fl_q.pf && irq_q))
    else $error("p_fire_sets_r9");

  p_read_clears_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_c && !fire && !upd_evt && !alm_evt) |=> (fl_q == '0 && !irq_q))
    else $error("p_read_clears_r11");

  p_event_survives_r12: assert property (@(posedge clk) disable iff (rst)
    (rd_c && fire) |=> (fl_q.pf && irq_q))
    else $error("p_event_survives_r12");
endmodule

// File: rtl/rtc_periodic_irq.sv
module rtc_periodic_irq
  import rtc_pir_pkg::*;
#(
  parameter int unsigned TICK_HZ = 65536,
  parameter int TICK_STEP = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       rd_c,
  output logic [7:0] rd_data,
  input  logic       upd_evt,
  input  logic       alm_evt,
  output logic       irq
);
  localparam int CW = $clog2(TICK_HZ + 1) + 1;

  logic [3:0]    rate_q, rate_nx;
  logic [2:0]    base_q, base_nx;
  logic          pie_q;
  logic          wr_a, wr_b;
  logic          pie_new, pie_chg, pie_drop;
  logic          reload, active, fire;
  logic          rate_on;
  logic [CW-1:0] period;
  logic [CW-1:0] remain;
  logic          unused_bits;

  assign wr_a     = wr_en & ~wr_sel;
  assign wr_b     = wr_en &  wr_sel;
  assign rate_nx  = wr_a ? wr_data[RATE_LSB +: 4] : rate_q;
  assign base_nx  = wr_a ? wr_data[BASE_LSB +: 3] : base_q;
  assign pie_new  = wr_data[PIE_BIT];
  assign pie_chg  = wr_b & (pie_new != pie_q);
  assign pie_drop = wr_b & ~pie_new;
  assign reload   = wr_a | pie_chg;
  assign active   = pie_q & rate_on;
  assign unused_bits = wr_data[7] ^ (^remain);

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= '0;
      base_q <= '0;
      pie_q  <= 1'b0;
    end else begin
      rate_q <= rate_nx;
      base_q <= base_nx;
      if (wr_b) pie_q <= pie_new;
    end
  end

  rtc_rate_decode #(.TICK_HZ(TICK_HZ), .CW(CW)) u_decode (
    .rate_code (rate_nx),
    .base_code (base_nx),
    .period    (period),
    .rate_on   (rate_on)
  );

  rtc_period_timer #(.CW(CW), .STEP(TICK_STEP)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .active  (active),
    .reload  (reload),
    .period  (period),
    .fire    (fire),
    .remain  (remain)
  );

  rtc_flag_reg u_flags (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire),
    .upd_evt  (upd_evt),
    .alm_evt  (alm_evt),
    .rd_c     (rd_c),
    .pie_drop (pie_drop),
    .status   (rd_data),
    .irq      (irq)
  );

  p_irq_needs_pie_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> pie_q)
    else $error("p_irq_needs_pie_r8");

  p_rate_zero_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (rate_q == 4'd0 && !wr_a) |-> !fire)
    else $error("p_rate_zero_quiet_r2");

  p_pie_off_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_b && !pie_new) |=> !irq)
    else $error("p_pie_off_drop_r8");
endmodule

// File: tb/rtc_periodic_irq_tb_top.sv
`timescale 1ns/1ps
module rtc_periodic_irq_tb_top;
  localparam int unsigned TICK_HZ = 65536;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_c = 1'b0;
  logic [7:0] rd_data;
  logic       upd_evt = 1'b0;
  logic       alm_evt = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int    exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  rtc_periodic_irq #(.TICK_HZ(TICK_HZ), .TICK_STEP(1)) dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_c(rd_c), .rd_data(rd_data), .upd_evt(upd_evt),
    .alm_evt(alm_evt), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: compares each status read against the scoreboard queue
  always @(negedge clk) begin
    #1;
    if (rd_c && !rst) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 actual=%0d expected=<none queued>", rd_data);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (e >= 0) chk(t, int'(rd_data), e);
      end
    end
  end

  // expected ticks per period, restated from the rate table
  function automatic int exp_period(input logic [7:0] a);
    int hz;
    bit slow;
    slow = (a[6:4] == 3'b010);
    case (a[3:0])
      4'd0: hz = 0;
      4'd1: hz = slow ? 256 : 32768;
      4'd2: hz = slow ? 128 : 16384;
      default: hz = 32768 >> (a[3:0] - 1);
    endcase
    return (hz == 0) ? 0 : int'(TICK_HZ) / hz;
  endfunction

  task automatic wr(input bit sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic rd(input int e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    rd_c = 1'b1;
    @(negedge clk);
    rd_c = 1'b0;
  endtask

  task automatic measure(output int n, input int lim);
    n = 0;
    while (n < lim) begin
      @(negedge clk);
      n++;
      if (irq) return;
    end
    n = -1;
  endtask

  task automatic arm(input logic [7:0] a);
    wr(1'b1, 8'h00);
    rd(-1, "");
    wr(1'b0, a);
    wr(1'b1, 8'h40);
  endtask

  task automatic period_case(input logic [7:0] a, input string tag);
    int n;
    arm(a);
    measure(n, exp_period(a) + 20);
    chk(tag, n, exp_period(a));
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1", int'(irq), 0);
    rd(8'h00, "R1");

    // R3 / R6 bit 7 ignored, 1 MHz base rate 3
    period_case(8'h93, "R6");
    rd(8'hC0, "R10");
    chk("R11", int'(irq), 0);
    rd(8'h00, "R11");

    // R9 back-to-back periods without drift
    period_case(8'h13, "R9");
    rd(8'hC0, "R9");
    measure(n, 40);
    chk("R9", n, exp_period(8'h13) - 1);

    // R4 base-dependent codes
    period_case(8'h21, "R4");
    period_case(8'h01, "R4");
    period_case(8'h22, "R4");
    period_case(8'h02, "R4");

    // R3 fixed codes
    period_case(8'h19, "R3");
    period_case(8'h23, "R3");
    period_case(8'h2F, "R3");

    // R2 rate 0
    arm(8'h20);
    repeat (300) @(negedge clk);
    chk("R2", int'(irq), 0);
    rd(8'h00, "R2");

    // R5 tick enable gating
    wr(1'b1, 8'h00);
    rd(-1, "");
    wr(1'b0, 8'h13);
    tick_en = 1'b0;
    wr(1'b1, 8'h40);
    repeat (50) @(negedge clk);
    chk("R5", int'(irq), 0);
    tick_en = 1'b1;
    measure(n, 40);
    chk("R5", n, 8);

    // R7 same enable rewritten: no restart
    arm(8'h13);
    repeat (5) @(negedge clk);
    wr(1'b1, 8'h40);
    measure(n, 40);
    chk("R7", n, 2);

    // R6 control A write restarts the period
    arm(8'h13);
    repeat (5) @(negedge clk);
    wr(1'b0, 8'h13);
    measure(n, 40);
    chk("R6", n, 8);

    // R8 disabling drops irq, flags kept
    arm(8'h13);
    measure(n, 40);
    chk("R8", n, 8);
    wr(1'b1, 8'h00);
    chk("R8", int'(irq), 0);
    rd(8'hC0, "R8");

    // R12 expiry and status read in the same cycle
    arm(8'h13);
    repeat (7) @(negedge clk);
    rd(8'h00, "R12");
    chk("R12", int'(irq), 1);
    rd(8'hC0, "R12");

    // R10 update and alarm flags
    wr(1'b1, 8'h00);
    rd(-1, "");
    upd_evt = 1'b1; @(negedge clk); upd_evt = 1'b0;
    chk("R10", int'(irq), 0);
    rd(8'h90, "R10");
    alm_evt = 1'b1; @(negedge clk); alm_evt = 1'b0;
    rd(8'hA0, "R10");
    upd_evt = 1'b1; alm_evt = 1'b1; @(negedge clk); upd_evt = 1'b0; alm_evt = 1'b0;
    rd(8'hB0, "R10");
    chk("R10", int'(irq), 0);

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule